// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock of an I2C master from a fast peripheral clock. Two 8-bit fields of a divisor word set how long the clock stays low and how long it stays high, each counted in peripheral-clock cycles. The low phase lasts one cycle more than its field. The high phase lasts two cycles more than its field. Both fields reset to 0x1F, which gives 32 cycles low and 33 cycles high. As an example, with a 26 MHz peripheral clock, a high field of 0x1D and a low field of 0x21 give about 1.2 us high and 1.3 us low, which is close to 400 kHz.

The generator watches the bus clock line. After it releases the line, it does not start counting the high phase until it sees the line high. A slave that holds the line low therefore stretches the clock. A byte engine beside this block uses the falling-edge and rising-edge strobes to place its data changes. The bus clock input must already be synchronised to the peripheral clock. Start and stop conditions, shifting and arbitration belong to other blocks.

Top module: `scl_clkgen`

## Requirements
- R1: Synchronous reset sets `rd_data` to 0x1F1F, releases `scl_out` (1) and holds both strobes at 0.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored as the divisor and appears on `rd_data` in the next cycle. Bits [15:8] hold the high field and bits [7:0] hold the low field.
- R3: Each low phase holds `scl_out` at 0 for exactly LOW+1 cycles, where LOW is the low field in force when the phase began.
- R4: Each high phase holds `scl_out` at 1 for exactly HIGH+2 cycles, counted from the first cycle in which `scl_in` is 1 after release. HIGH is the high field in force when the line was released.
- R5: While `scl_out` is released and `scl_in` stays 0 before counting has begun, `scl_out` stays 1 and no new low phase starts.
- R6: A divisor write made during a phase leaves that phase's length unchanged. A new low field applies from the next low phase. A new high field applies from the next release.
- R7: When `enable` is sampled low, `scl_out` is 1 from the next cycle on. A later edge with `enable` high starts a complete low phase, with `scl_out` 0 in the following cycle.
- R8: `fall_stb` is 1 exactly in the first cycle of `scl_out`=0 after a 1. `rise_stb` is 1 exactly in the first cycle of `scl_out`=1 after a 0. The two strobes are never 1 together.
- R9: `scl_in` has no effect on timing during a low phase or once high-phase counting has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the clock generator |
| wr_en | input | 1 | Divisor write strobe |
| wr_data | input | 16 | Divisor write value {high, low} |
| rd_data | output | 16 | Current divisor value |
| scl_in | input | 1 | Synchronised bus clock level |
| scl_out | output | 1 | Clock drive level, 1 = released |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a release |

## Verification
The hardest situation to reach from the ports is a bus line that disagrees with the drive level. This happens when a slave stretches the clock in the waiting window, or when the line glitches after high-phase counting has started. The bench ties `scl_in` to `scl_out` and gates it with its own stretch control. It holds the stretch across whole releases, pulses it for one cycle inside counted high phases, and then runs a long periodic stretch pattern. Divisor writes land mid-phase so that the two fields' separate latch points are both exercised.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    // extra cycles added on top of each programmed field
    localparam int unsigned LOW_EXTRA  = 1;
    localparam int unsigned HIGH_EXTRA = 2;

    localparam int unsigned DEF_FIELD_W = 8;

    function automatic logic drives_low(phase_e ph);
        return ph == PH_LOW;
    endfunction

endpackage

// File: rtl/scl_div_reg.sv
module scl_div_reg #(
    parameter int unsigned       FIELD_W  = 8,
    parameter logic [FIELD_W-1:0] HIGH_RST = '1,
    parameter logic [FIELD_W-1:0] LOW_RST  = '1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [2*FIELD_W-1:0]   wr_data,
    output logic [FIELD_W-1:0]     div_hi,
    output logic [FIELD_W-1:0]     div_lo
);
    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } div_t;

    div_t div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q.hi <= HIGH_RST;
            div_q.lo <= LOW_RST;
        end else if (wr_en) begin
            div_q <= div_t'(wr_data);
        end
    end

    assign div_hi = div_q.hi;
    assign div_lo = div_q.lo;
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_clkgen_pkg::*;
#(
    parameter int unsigned FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               scl_in,
    input  logic [FIELD_W-1:0] div_hi,
    input  logic [FIELD_W-1:0] div_lo,
    output logic               scl_out,
    output logic [FIELD_W-1:0] lo_active,
    output logic [FIELD_W-1:0] hi_active
);
    localparam int unsigned CNT_W = FIELD_W + 1;

    phase_e             phase_q, phase_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [FIELD_W-1:0] lo_q, lo_d, hi_q, hi_d;
    logic               low_done, high_done;

    // low phase ends after lo+LOW_EXTRA cycles (count 0..lo)
    assign low_done  = cnt_q == {1'b0, lo_q} + CNT_W'(LOW_EXTRA - 1);
    // the waiting cycle that saw the line high counts as the first high cycle
    assign high_done = cnt_q == {1'b0, hi_q} + CNT_W'(HIGH_EXTRA - 1);

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        lo_d    = lo_q;
        hi_d    = hi_q;
        if (!enable) begin
            phase_d = PH_OFF;
            cnt_d   = '0;
        end else begin
            unique case (phase_q)
                PH_OFF: begin
                    phase_d = PH_LOW;
                    cnt_d   = '0;
                    lo_d    = div_lo;
                end
                PH_LOW: begin
                    if (low_done) begin
                        phase_d = PH_WAIT;
                        cnt_d   = '0;
                        hi_d    = div_hi;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (scl_in) begin
                        phase_d = PH_HIGH;
                        cnt_d   = CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (high_done) begin
                        phase_d = PH_LOW;
                        cnt_d   = '0;
                        lo_d    = div_lo;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            lo_q    <= lo_d;
            hi_q    <= hi_d;
        end
    end

    assign scl_out   = !drives_low(phase_q);
    assign lo_active = lo_q;
    assign hi_active = hi_q;
endmodule

// File: rtl/scl_edge_strobe.sv
module scl_edge_strobe (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic fall_stb,
    output logic rise_stb
);
    logic level_d;

    always_ff @(posedge clk) begin
        if (rst) level_d <= 1'b1;
        else     level_d <= level;
    end

    assign fall_stb = level_d & ~level;
    assign rise_stb = ~level_d & level;
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_clkgen_pkg::*;
#(
    parameter int unsigned        FIELD_W  = DEF_FIELD_W,
    parameter logic [FIELD_W-1:0] HIGH_RST = FIELD_W'(8'h1F),
    parameter logic [FIELD_W-1:0] LOW_RST  = FIELD_W'(8'h1F)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 wr_en,
    input  logic [2*FIELD_W-1:0] wr_data,
    output logic [2*FIELD_W-1:0] rd_data,
    input  logic                 scl_in,
    output logic                 scl_out,
    output logic                 fall_stb,
    output logic                 rise_stb
);
    logic [FIELD_W-1:0] div_hi, div_lo;
    logic [FIELD_W-1:0] lo_active, hi_active;

    scl_div_reg #(
        .FIELD_W (FIELD_W),
        .HIGH_RST(HIGH_RST),
        .LOW_RST (LOW_RST)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .div_hi (div_hi),
        .div_lo (div_lo)
    );

    scl_phase_seq #(
        .FIELD_W(FIELD_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .scl_in   (scl_in),
        .div_hi   (div_hi),
        .div_lo   (div_lo),
        .scl_out  (scl_out),
        .lo_active(lo_active),
        .hi_active(hi_active)
    );

    scl_edge_strobe u_stb (
        .clk     (clk),
        .rst     (rst),
        .level   (scl_out),
        .fall_stb(fall_stb),
        .rise_stb(rise_stb)
    );

    assign rd_data = {div_hi, div_lo};
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
    parameter int unsigned        FIELD_W  = 8,
    parameter logic [FIELD_W-1:0] HIGH_RST = '1,
    parameter logic [FIELD_W-1:0] LOW_RST  = '1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 enable,
    input logic [2*FIELD_W-1:0] rd_data,
    input logic                 scl_in,
    input logic                 scl_out,
    input logic                 fall_stb,
    input logic                 rise_stb,
    input logic [FIELD_W-1:0]   lo_active,
    input logic [FIELD_W-1:0]   hi_active
);
    localparam int unsigned RUN_W = FIELD_W + 2;

    logic [RUN_W-1:0] low_run, hi_run;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            low_run <= '0;
            hi_run  <= '0;
            armed   <= 1'b0;
        end else begin
            low_run <= scl_out ? '0 : low_run + 1'b1;
            if (rise_stb) armed <= 1'b1;
            if (!scl_out)
                hi_run <= '0;
            else if ((armed || rise_stb) && (hi_run != '0 || scl_in))
                hi_run <= hi_run + 1'b1;
        end
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (rd_data == {HIGH_RST, LOW_RST} && scl_out));

    // R3
    low_length_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(scl_out) && $past(enable)) |-> (low_run == RUN_W'(lo_active) + RUN_W'(1)));

    // R4
    high_length_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_out) && $past(enable) && $past(armed)) |-> (hi_run == RUN_W'(hi_active) + RUN_W'(2)));

    // R5
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && scl_out && (armed || rise_stb) && hi_run == '0 && !scl_in) |=> scl_out);

    // R7
    disable_release_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (scl_out && !fall_stb));

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fall_stb && rise_stb));

    // R8
    fall_mark_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_out) |-> fall_stb);

    // R8
    rise_mark_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_out) |-> rise_stb);
endmodule

bind scl_clkgen scl_clkgen_chk #(
    .FIELD_W (FIELD_W),
    .HIGH_RST(HIGH_RST),
    .LOW_RST (LOW_RST)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .rd_data  (rd_data),
    .scl_in   (scl_in),
    .scl_out  (scl_out),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb),
    .lo_active(lo_active),
    .hi_active(hi_active)
);

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        scl_in, scl_out, fall_stb, rise_stb;
    logic        stretch = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    assign scl_in = scl_out & ~stretch;

    scl_clkgen u_scl_clkgen (
        .clk(clk), .rst(rst), .enable(enable),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .scl_in(scl_in), .scl_out(scl_out),
        .fall_stb(fall_stb), .rise_stb(rise_stb)
    );

    // behavioural reference: remaining-cycle countdown per phase
    int m_hi = 31, m_lo = 31;
    int m_state = 0;      // 0 idle, 1 driving low, 2 released waiting, 3 high counting
    int m_left = 0;
    int m_hi_use = 0;
    bit m_out = 1, m_fall = 0, m_rise = 0;

    always @(posedge clk) begin
        bit prev;
        prev = m_out;
        if (rst) begin
            m_hi = 31; m_lo = 31; m_state = 0; m_left = 0;
            m_out = 1; m_fall = 0; m_rise = 0;
        end else begin
            if (!enable) begin
                m_state = 0;
            end else if (m_state == 0) begin
                m_state = 1; m_left = m_lo + 1;
            end else if (m_state == 1) begin
                m_left--;
                if (m_left == 0) begin m_state = 2; m_hi_use = m_hi; end
            end else if (m_state == 2) begin
                if (m_out && !stretch) begin m_state = 3; m_left = m_hi_use + 1; end
            end else begin
                m_left--;
                if (m_left == 0) begin m_state = 1; m_left = m_lo + 1; end
            end
            if (wr_en) begin m_hi = wr_data[15:8]; m_lo = wr_data[7:0]; end
            m_out  = (m_state != 1);
            m_fall = prev && !m_out;
            m_rise = !prev && m_out;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            checks++;
            if (scl_out !== m_out || fall_stb !== m_fall || rise_stb !== m_rise ||
                rd_data !== {m_hi[7:0], m_lo[7:0]}) begin
                fails++;
                $display("FAIL %s cycle compare: got scl=%0b fall=%0b rise=%0b div=%h, expected scl=%0b fall=%0b rise=%0b div=%h",
                         cur_req, scl_out, fall_stb, rise_stb, rd_data,
                         m_out, m_fall, m_rise, {m_hi[7:0], m_lo[7:0]});
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_div(input int hi, input int lo);
        @(negedge clk);
        wr_en = 1; wr_data = {hi[7:0], lo[7:0]};
        @(negedge clk);
        wr_en = 0;
        chk("R2", int'(rd_data), (hi << 8) | lo, "divisor readback");
    endtask

    task automatic wait_fall();
        do @(negedge clk); while (!fall_stb);
    endtask

    // measure the next full low phase and the high phase after it
    task automatic measure(input int exp_low, input int exp_high);
        int n;
        wait_fall();
        n = 1;
        forever begin @(negedge clk); if (scl_out) break; n++; end
        chk("R3", n, exp_low, "low phase length");
        chk("R8", int'(rise_stb), 1, "rise strobe at release");
        n = 1;
        forever begin @(negedge clk); if (!scl_out) break; n++; end
        chk("R4", n, exp_high, "high phase length");
        chk("R8", int'(fall_stb), 1, "fall strobe at drive");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", int'(rd_data), 16'h1F1F, "reset divisor");
        chk("R1", int'(scl_out), 1, "reset scl level");
        chk("R1", int'(fall_stb | rise_stb), 0, "reset strobes");
        cmp_on = 1;

        cur_req = "R3";
        enable = 1;
        @(negedge clk);
        chk("R7", int'(scl_out), 0, "drive low after enable");
        measure(32, 33);

        cur_req = "R2";
        write_div(0, 0);
        measure(1, 2);
        write_div(8'h1D, 8'h21);
        measure(34, 31);
        write_div(8'hFF, 8'hFF);
        measure(256, 257);
        write_div(2, 5);
        measure(6, 4);

        // R6: write in the middle of a low phase
        cur_req = "R6";
        wait_fall();
        n = 1;
        @(negedge clk); n++;
        wr_en = 1; wr_data = {8'd8, 8'd10};
        @(negedge clk); n++;
        wr_en = 0;
        forever begin @(negedge clk); if (scl_out) break; n++; end
        chk("R6", n, 6, "low phase unchanged by mid-phase write");
        n = 1;
        forever begin @(negedge clk); if (!scl_out) break; n++; end
        chk("R6", n, 10, "new high field at next release");
        n = 1;
        forever begin @(negedge clk); if (scl_out) break; n++; end
        chk("R6", n, 11, "new low field at next low phase");

        // R5: slave holds the line through a release
        cur_req = "R5";
        write_div(3, 3);
        wait_fall();
        stretch = 1;
        do @(negedge clk); while (!scl_out);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R5", int'(scl_out), 1, "released while stretched");
        end
        stretch = 0;
        n = 1;
        forever begin @(negedge clk); if (!scl_out) break; n++; end
        chk("R5", n, 5, "high count starts after stretch ends");

        // R9: glitch inside counted high phase and inside low phase
        cur_req = "R9";
        do @(negedge clk); while (!rise_stb);
        n = 1;
        @(negedge clk); n++;
        stretch = 1;
        @(negedge clk); n++;
        stretch = 0;
        forever begin @(negedge clk); if (!scl_out) break; n++; end
        chk("R9", n, 5, "high length with line glitch");
        n = 1;
        @(negedge clk); n++;
        stretch = 1;
        @(negedge clk); n++;
        stretch = 0;
        forever begin @(negedge clk); if (scl_out) break; n++; end
        chk("R9", n, 4, "low length with line glitch");

        // R5 / R9: periodic stretch pattern checked by the model
        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            stretch = ((i % 11) < 3) || ((i % 17) == 5);
        end
        stretch = 0;

        // R7: disable in mid low phase, then re-enable
        cur_req = "R7";
        wait_fall();
        repeat (2) @(negedge clk);
        enable = 0;
        @(negedge clk);
        chk("R7", int'(scl_out), 1, "released after disable");
        chk("R8", int'(rise_stb), 1, "rise strobe on disable release");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R7", int'(scl_out | (fall_stb << 1) | (rise_stb << 2)), 1, "idle while disabled");
        end
        enable = 1;
        @(negedge clk);
        chk("R7", int'(fall_stb), 1, "fall strobe after re-enable");
        n = 1;
        forever begin @(negedge clk); if (scl_out) break; n++; end
        chk("R7", n, 4, "full low phase after re-enable");

        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule